// File: doc/BRIEF.md
# Battery pack paralleling sequencer

This block adds a second, isolated battery pack to a shared high-voltage bus that is already live. It works on digitised measurements: bus voltage, joining-pack voltage and pre-charge path current arrive as unsigned fixed-point words, each with its own valid strobe. It also reads feedback contacts from the two contactors of the joining pack. From these it drives the pre-charge and main contactor commands, reports its step as a state code, raises a done flag once the pack shares the bus, and keeps a fault code that names the step that failed.

A start request first passes a hard voltage gate. If the gap between the pack and the bus is larger than a tolerance set at build time, the request is refused and no contactor ever moves. Once the gate is passed, the contactors follow one fixed order: the pre-charge contactor closes; the machine waits until both current and voltage gap are small; the main contactor closes straight away; and the pre-charge contactor opens last. Each step must be confirmed by feedback or by measurement within a bounded window. Any failure opens both contactors, stores a fault code and returns the machine to idle. The fault code stays set until software clears it while the machine is idle.

Top module: `pack_join_seq`

## Requirements
- R1: After reset the machine is idle with both commands low, done low and fault code 0. State codes are: 0 idle, 1 voltage check, 2 pre-charge closing, 3 equalising, 4 main closing, 5 pre-charge releasing, 6 running.
- R2: A start request moves the machine to the check state (1). At the first registered sample in which both voltage strobes were high, an absolute gap greater than MATCH_TOL ends the sequence in idle with fault 1, and the pre-charge command is never raised. A gap of exactly MATCH_TOL or less raises the pre-charge command (state 2).
- R3: A voltage or current word is ignored on any cycle where its valid strobe is low. Mismatched words presented without strobes leave the check state waiting.
- R4: Contactor commands follow this order: pre-charge closes first, then main closes while pre-charge is still closed, then pre-charge opens once main feedback has confirmed.
- R5: Equalisation is declared only from a single sample in which all three strobes are high, the current is below EQ_I and the voltage gap is below EQ_DV. A sample that meets only one of these conditions is ignored.
- R6: If equalisation is not reached within EQ_TO cycles of entering state 3, the sequence aborts with fault 3. A qualifying sample evaluated on the last cycle of that window still wins over the timeout.
- R7: The main command rises on the clock edge that follows the edge that captured the qualifying sample, with no extra delay.
- R8: Each feedback must confirm within FB_TO cycles of entering its state. Otherwise the sequence aborts with fault 2 (pre-charge did not close), fault 4 (main did not close) or fault 5 (pre-charge did not open).
- R9: On every abort both contactor commands go low in the same cycle that the fault code appears and the state returns to 0.
- R10: In state 6, done is high, main is commanded and pre-charge is open. A stop request returns the machine to idle with both commands low and no fault. The pack fault input, in any non-idle state, aborts with fault 6.
- R11: A non-zero fault code stays latched and start requests are ignored while it is set. Pulsing clear in idle sets the code to 0. When clear and start arrive in the same cycle, the clear is taken and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to add the pack |
| stop_req | input | 1 | Request to remove the pack from the running state |
| pack_fault | input | 1 | Fault reported by the joining pack's own monitor |
| clr_fault | input | 1 | Clears the latched fault code (honoured only in idle) |
| bus_v | input | VW | Bus voltage sample |
| bus_v_vld | input | 1 | Strobe for bus_v |
| pack_v | input | VW | Joining pack voltage sample |
| pack_v_vld | input | 1 | Strobe for pack_v |
| pre_i | input | IW | Pre-charge path current sample |
| pre_i_vld | input | 1 | Strobe for pre_i |
| pre_fb | input | 1 | Pre-charge contactor feedback, high when closed |
| main_fb | input | 1 | Main contactor feedback, high when closed |
| pre_cmd | output | 1 | Pre-charge contactor close command |
| main_cmd | output | 1 | Main contactor close command |
| state_code | output | 3 | Current step (see R1) |
| done | output | 1 | Pack is sharing the bus |
| fault_code | output | 3 | Latched fault code (see R2, R6, R8, R10) |

## Verification
Two pairs of events can fall in the same cycle. The first pair is equalisation and the end of its timeout window. The bench waits until exactly one evaluation remains in the window, then presents a qualifying sample, and it expects the main-closing state rather than fault 3. The second pair is a clear and a new start in idle. The bench pulses both together while a fault is latched, and it expects the fault to read 0 with the machine still idle and no pre-charge command.

// File: rtl/pjs_pkg.sv
package pjs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_PRECH   = 3'd2,
        ST_EQUAL   = 3'd3,
        ST_MAIN    = 3'd4,
        ST_RELEASE = 3'd5,
        ST_RUN     = 3'd6
    } seq_state_t;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_MISMATCH   = 3'd1,
        FLT_PRE_FB     = 3'd2,
        FLT_EQ_TIMEOUT = 3'd3,
        FLT_MAIN_FB    = 3'd4,
        FLT_RELEASE    = 3'd5,
        FLT_PACK       = 3'd6
    } seq_fault_t;

    typedef struct packed {
        logic pair_vld;  // both voltages valid in this registered sample
        logic mismatch;  // voltage gap beyond the join tolerance
        logic eq_ok;     // current and gap both small, all strobes valid
    } judge_t;

    function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pjs_sample.sv
module pjs_sample #(
    parameter int VW = 12,
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] bus_v,
    input  logic          bus_v_vld,
    input  logic [VW-1:0] pack_v,
    input  logic          pack_v_vld,
    input  logic [IW-1:0] pre_i,
    input  logic          pre_i_vld,
    output logic [VW-1:0] s_bus,
    output logic          s_bus_vld,
    output logic [VW-1:0] s_pack,
    output logic          s_pack_vld,
    output logic [IW-1:0] s_cur,
    output logic          s_cur_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_bus_vld  <= 1'b0;
            s_pack_vld <= 1'b0;
            s_cur_vld  <= 1'b0;
            s_bus      <= '0;
            s_pack     <= '0;
            s_cur      <= '0;
        end else begin
            s_bus_vld  <= bus_v_vld;
            s_pack_vld <= pack_v_vld;
            s_cur_vld  <= pre_i_vld;
            // words are captured only with their own strobe
            if (bus_v_vld)  s_bus  <= bus_v;
            if (pack_v_vld) s_pack <= pack_v;
            if (pre_i_vld)  s_cur  <= pre_i;
        end
    end

endmodule

// File: rtl/pjs_judge.sv
module pjs_judge
    import pjs_pkg::*;
#(
    parameter int VW        = 12,
    parameter int IW        = 12,
    parameter int MATCH_TOL = 40,
    parameter int EQ_DV     = 4,
    parameter int EQ_I      = 8
) (
    input  logic [VW-1:0] s_bus,
    input  logic          s_bus_vld,
    input  logic [VW-1:0] s_pack,
    input  logic          s_pack_vld,
    input  logic [IW-1:0] s_cur,
    input  logic          s_cur_vld,
    output judge_t        jd
);

    localparam logic [31:0] TOL_L = 32'(MATCH_TOL);
    localparam logic [31:0] DV_L  = 32'(EQ_DV);
    localparam logic [31:0] I_L   = 32'(EQ_I);

    logic [31:0] gap;
    logic [31:0] cur_w;

    always_comb begin
        gap         = abs_gap(32'(s_bus), 32'(s_pack));
        cur_w       = 32'(s_cur);
        jd.pair_vld = s_bus_vld && s_pack_vld;
        jd.mismatch = gap > TOL_L;
        jd.eq_ok    = jd.pair_vld && s_cur_vld && (gap < DV_L) && (cur_w < I_L);
    end

endmodule

// File: rtl/pjs_timer.sv
module pjs_timer #(
    parameter int FB_TO = 8,
    parameter int EQ_TO = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic fb_last,
    output logic eq_last
);

    localparam int LIM = (FB_TO > EQ_TO) ? FB_TO : EQ_TO;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIM);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign fb_last = (cnt == CW'(FB_TO - 1));
    assign eq_last = (cnt == CW'(EQ_TO - 1));

endmodule

// File: rtl/pack_join_seq.sv
module pack_join_seq
    import pjs_pkg::*;
#(
    parameter int VW        = 12,
    parameter int IW        = 12,
    parameter int MATCH_TOL = 40,
    parameter int EQ_DV     = 4,
    parameter int EQ_I      = 8,
    parameter int FB_TO     = 8,
    parameter int EQ_TO     = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          pack_fault,
    input  logic          clr_fault,
    input  logic [VW-1:0] bus_v,
    input  logic          bus_v_vld,
    input  logic [VW-1:0] pack_v,
    input  logic          pack_v_vld,
    input  logic [IW-1:0] pre_i,
    input  logic          pre_i_vld,
    input  logic          pre_fb,
    input  logic          main_fb,
    output logic          pre_cmd,
    output logic          main_cmd,
    output logic [2:0]    state_code,
    output logic          done,
    output logic [2:0]    fault_code
);

    logic [VW-1:0] s_bus, s_pack;
    logic [IW-1:0] s_cur;
    logic          s_bus_vld, s_pack_vld, s_cur_vld;
    judge_t        jd;
    logic          fb_last, eq_last;

    seq_state_t st, nxt;
    seq_fault_t fault_q, new_fault;
    logic       set_fault;

    pjs_sample #(.VW(VW), .IW(IW)) u_sample (
        .clk(clk), .rst(rst),
        .bus_v(bus_v), .bus_v_vld(bus_v_vld),
        .pack_v(pack_v), .pack_v_vld(pack_v_vld),
        .pre_i(pre_i), .pre_i_vld(pre_i_vld),
        .s_bus(s_bus), .s_bus_vld(s_bus_vld),
        .s_pack(s_pack), .s_pack_vld(s_pack_vld),
        .s_cur(s_cur), .s_cur_vld(s_cur_vld)
    );

    pjs_judge #(.VW(VW), .IW(IW), .MATCH_TOL(MATCH_TOL), .EQ_DV(EQ_DV), .EQ_I(EQ_I)) u_judge (
        .s_bus(s_bus), .s_bus_vld(s_bus_vld),
        .s_pack(s_pack), .s_pack_vld(s_pack_vld),
        .s_cur(s_cur), .s_cur_vld(s_cur_vld),
        .jd(jd)
    );

    pjs_timer #(.FB_TO(FB_TO), .EQ_TO(EQ_TO)) u_timer (
        .clk(clk), .rst(rst),
        .restart((nxt != st) || (st == ST_IDLE)),
        .fb_last(fb_last), .eq_last(eq_last)
    );

    // next-step decision; an abort always lands in idle with a fault
    always_comb begin
        nxt       = st;
        set_fault = 1'b0;
        new_fault = FLT_NONE;
        if (st != ST_IDLE && pack_fault) begin
            nxt = ST_IDLE; set_fault = 1'b1; new_fault = FLT_PACK;
        end else begin
            case (st)
                ST_IDLE:
                    if (start_req && fault_q == FLT_NONE && !clr_fault) nxt = ST_CHECK;
                ST_CHECK:
                    if (jd.pair_vld) begin
                        if (jd.mismatch) begin
                            nxt = ST_IDLE; set_fault = 1'b1; new_fault = FLT_MISMATCH;
                        end else begin
                            nxt = ST_PRECH;
                        end
                    end
                ST_PRECH:
                    if (pre_fb) nxt = ST_EQUAL;
                    else if (fb_last) begin
                        nxt = ST_IDLE; set_fault = 1'b1; new_fault = FLT_PRE_FB;
                    end
                ST_EQUAL:
                    if (jd.eq_ok) nxt = ST_MAIN;
                    else if (eq_last) begin
                        nxt = ST_IDLE; set_fault = 1'b1; new_fault = FLT_EQ_TIMEOUT;
                    end
                ST_MAIN:
                    if (main_fb) nxt = ST_RELEASE;
                    else if (fb_last) begin
                        nxt = ST_IDLE; set_fault = 1'b1; new_fault = FLT_MAIN_FB;
                    end
                ST_RELEASE:
                    if (!pre_fb) nxt = ST_RUN;
                    else if (fb_last) begin
                        nxt = ST_IDLE; set_fault = 1'b1; new_fault = FLT_RELEASE;
                    end
                ST_RUN:
                    if (stop_req) nxt = ST_IDLE;
                default:
                    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            fault_q <= FLT_NONE;
        end else begin
            st <= nxt;
            if (set_fault)
                fault_q <= new_fault;
            else if (st == ST_IDLE && clr_fault)
                fault_q <= FLT_NONE;
        end
    end

    assign pre_cmd    = (st == ST_PRECH) || (st == ST_EQUAL) || (st == ST_MAIN);
    assign main_cmd   = (st == ST_MAIN) || (st == ST_RELEASE) || (st == ST_RUN);
    assign done       = (st == ST_RUN);
    assign state_code = st;
    assign fault_code = fault_q;

    // R4: main closes only while pre-charge is still commanded
    a_r4_main_behind_pre: assert property (@(posedge clk) disable iff (rst)
        $rose(main_cmd) |-> pre_cmd);

    // R4: pre-charge opens with main held only after main feedback confirmed
    a_r4_release_confirmed: assert property (@(posedge clk) disable iff (rst)
        ($fell(pre_cmd) && main_cmd) |-> $past(main_fb));

    // R9: a freshly latched fault coincides with open contactors and idle
    a_r9_abort_opens_all: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0 && $past(fault_code) == 3'd0) |-> (!pre_cmd && !main_cmd && state_code == 3'd0));

    // R2: a mismatch refusal never touched the pre-charge contactor
    a_r2_refusal_no_precharge: assert property (@(posedge clk) disable iff (rst)
        (fault_code == 3'd1 && $past(fault_code) == 3'd0) |-> ($past(!pre_cmd) && !pre_cmd));

    // R11: a latched fault is released only by clear in idle
    a_r11_clear_in_idle: assert property (@(posedge clk) disable iff (rst)
        (fault_code == 3'd0 && $past(fault_code) != 3'd0) |-> ($past(clr_fault) && $past(state_code) == 3'd0));

    // R10: done only with the pack on the main path alone
    a_r10_done_main_only: assert property (@(posedge clk) disable iff (rst)
        done |-> (main_cmd && !pre_cmd));

endmodule

// File: tb/tb_pack_join_seq.sv
module tb_pack_join_seq;

    localparam int VW = 12;
    localparam int IW = 12;
    localparam int TOL = 40;
    localparam int FBT = 5;
    localparam int EQT = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 0, stop_req = 0, pack_fault = 0, clr_fault = 0;
    logic [VW-1:0] bus_v = '0, pack_v = '0;
    logic [IW-1:0] pre_i = '0;
    logic bus_v_vld = 0, pack_v_vld = 0, pre_i_vld = 0;
    logic pre_fb = 0, main_fb = 0;
    logic pre_cmd, main_cmd, done;
    logic [2:0] state_code, fault_code;

    int n_chk = 0;
    int n_fail = 0;

    pack_join_seq #(.VW(VW), .IW(IW), .MATCH_TOL(TOL), .EQ_DV(4), .EQ_I(8),
                    .FB_TO(FBT), .EQ_TO(EQT)) dut (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .pack_fault(pack_fault), .clr_fault(clr_fault),
        .bus_v(bus_v), .bus_v_vld(bus_v_vld), .pack_v(pack_v), .pack_v_vld(pack_v_vld),
        .pre_i(pre_i), .pre_i_vld(pre_i_vld), .pre_fb(pre_fb), .main_fb(main_fb),
        .pre_cmd(pre_cmd), .main_cmd(main_cmd), .state_code(state_code),
        .done(done), .fault_code(fault_code)
    );

    always #2.5 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sample(input int bv, input int pv, input int ci);
        bus_v = VW'(bv); pack_v = VW'(pv); pre_i = IW'(ci);
        bus_v_vld = 1; pack_v_vld = 1; pre_i_vld = 1;
        tick();
        bus_v_vld = 0; pack_v_vld = 0; pre_i_vld = 0;
    endtask

    task automatic start_seq(input int bv, input int pv);
        start_req = 1;
        bus_v = VW'(bv); pack_v = VW'(pv);
        bus_v_vld = 1; pack_v_vld = 1;
        tick();
        start_req = 0; bus_v_vld = 0; pack_v_vld = 0;
    endtask

    task automatic clear_fault();
        clr_fault = 1; tick(); clr_fault = 0;
    endtask

    task automatic reach_equal();
        start_seq(1000, 1002);
        tick();
        pre_fb = 1;
        tick();
        chk("R4 entered equalising", state_code, 3);
    endtask

    task automatic t_reset();
        rst = 1; repeat (3) tick(); rst = 0; tick();
        chk("R1 reset state", state_code, 0);
        chk("R1 reset pre_cmd", pre_cmd, 0);
        chk("R1 reset main_cmd", main_cmd, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset fault", fault_code, 0);
    endtask

    task automatic t_mismatch();
        start_seq(1000, 950);
        chk("R2 check state", state_code, 1);
        chk("R2 no pre in check", pre_cmd, 0);
        tick();
        chk("R2 refused to idle", state_code, 0);
        chk("R2 mismatch fault", fault_code, 1);
        chk("R2 pre never raised", pre_cmd, 0);
        clear_fault();
        chk("R11 clear in idle", fault_code, 0);
    endtask

    task automatic t_tol_edge();
        start_seq(1040, 1000);
        tick();
        chk("R2 gap equal to tolerance accepted", state_code, 2);
        chk("R2 pre raised", pre_cmd, 1);
        pack_fault = 1; tick(); pack_fault = 0;
        chk("R10 pack fault idle", state_code, 0);
        chk("R10 pack fault code", fault_code, 6);
        chk("R9 pack fault opens pre", pre_cmd, 0);
        clear_fault();
    endtask

    task automatic t_strobe_and_pre_fb();
        start_req = 1; bus_v = VW'(1000); pack_v = VW'(900);
        tick(); start_req = 0;
        tick(); tick();
        chk("R3 unstrobed words ignored", state_code, 1);
        chk("R3 no fault from unstrobed", fault_code, 0);
        sample(1000, 1001, 50);
        tick();
        chk("R3 strobed sample accepted", state_code, 2);
        repeat (FBT - 1) tick();
        chk("R8 pre fb window open", state_code, 2);
        tick();
        chk("R8 pre fb timeout fault", fault_code, 2);
        chk("R9 pre fb abort idle", state_code, 0);
        chk("R9 pre fb abort pre open", pre_cmd, 0);
        clear_fault();
    endtask

    task automatic t_happy();
        reach_equal();
        sample(1000, 1001, 20);
        tick();
        chk("R5 high current ignored", state_code, 3);
        sample(1000, 1010, 3);
        tick();
        chk("R5 large gap ignored", state_code, 3);
        sample(1000, 1002, 3);
        chk("R7 main not before decision", main_cmd, 0);
        tick();
        chk("R7 main closes promptly", main_cmd, 1);
        chk("R4 pre still closed with main", pre_cmd, 1);
        chk("R4 main closing state", state_code, 4);
        main_fb = 1; tick();
        chk("R4 releasing state", state_code, 5);
        chk("R4 pre opened after main fb", pre_cmd, 0);
        chk("R4 main held", main_cmd, 1);
        pre_fb = 0; tick();
        chk("R10 running", state_code, 6);
        chk("R10 done", done, 1);
        stop_req = 1; tick(); stop_req = 0;
        chk("R10 stop to idle", state_code, 0);
        chk("R10 stop opens main", main_cmd, 0);
        chk("R10 stop no fault", fault_code, 0);
        main_fb = 0;
    endtask

    task automatic t_eq_timeout();
        reach_equal();
        repeat (EQT - 1) tick();
        chk("R6 window still open", state_code, 3);
        tick();
        chk("R6 equalise timeout fault", fault_code, 3);
        chk("R9 timeout pre open", pre_cmd, 0);
        chk("R9 timeout main open", main_cmd, 0);
        pre_fb = 0;
        clear_fault();
    endtask

    task automatic t_eq_last_and_main_fb();
        reach_equal();
        repeat (EQT - 2) tick();
        sample(1000, 1001, 1);
        tick();
        chk("R6 equalise on last cycle wins", state_code, 4);
        chk("R6 no timeout fault", fault_code, 0);
        repeat (FBT - 1) tick();
        chk("R8 main fb window open", state_code, 4);
        tick();
        chk("R8 main fb timeout fault", fault_code, 4);
        chk("R9 main abort main open", main_cmd, 0);
        chk("R9 main abort pre open", pre_cmd, 0);
        pre_fb = 0;
        clear_fault();
    endtask

    task automatic t_release_fail();
        reach_equal();
        sample(1000, 1000, 0);
        tick();
        main_fb = 1; tick();
        chk("R4 releasing", state_code, 5);
        repeat (FBT - 1) tick();
        chk("R8 release window open", state_code, 5);
        tick();
        chk("R8 release fault", fault_code, 5);
        chk("R9 release abort main open", main_cmd, 0);
        pre_fb = 0; main_fb = 0;
        clear_fault();
    endtask

    task automatic t_fault_lock();
        start_seq(1000, 900);
        tick();
        chk("R11 fault set", fault_code, 1);
        start_seq(1000, 1000);
        tick();
        chk("R11 start ignored while latched", state_code, 0);
        chk("R11 fault kept", fault_code, 1);
        clr_fault = 1; start_req = 1; tick();
        clr_fault = 0; start_req = 0;
        tick();
        chk("R11 clear wins fault", fault_code, 0);
        chk("R11 clear wins state", state_code, 0);
        chk("R11 clear wins no pre", pre_cmd, 0);
        start_seq(1000, 1000);
        tick();
        chk("R11 start after clear", state_code, 2);
        pack_fault = 1; tick(); pack_fault = 0;
        clear_fault();
    endtask

    initial begin
        t_reset();
        t_mismatch();
        t_tol_edge();
        t_strobe_and_pre_fb();
        t_happy();
        t_eq_timeout();
        t_eq_last_and_main_fb();
        t_release_fail();
        t_fault_lock();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule